// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits behind a simple synchronous bus port and behaves like the command front end of a NOR flash that uses a multi-write unlock protocol. It follows the write-cycle position and the active command. From the bus writes it recognises the unlock handshake, program, sector and chip erase, identification (autoselect), a bypass mode that skips the unlock pair, reset, and entry into the query table. It also decides what every read returns: array contents, an identification word, a query-table byte, or the status word supplied from outside.

Storage is a small internal array of bus-width words. Resetting the array sets it to the erased (all ones) state. A program write can only clear bits. Erase timing and status-bit generation belong to a sibling block. That block watches `erase_busy`, drives `status_in` and pulses `erase_done` when an erase finishes. The bus width (1, 2 or 4 bytes), the array depth, the sector size, the two unlock addresses and the four identification words are parameters.

Top module: `flash_cmd_seq`

## Requirements
- R1: The word address is the byte address shifted right by log2(BUS_BYTES). Only the low 11 bits of the word address are compared against unlock addresses and the query address 0x55. Higher address bits therefore alias.
- R2: The unlock pair is written in this order: data 0xAA to UNLOCK_ADDR0, then data 0x55 to UNLOCK_ADDR1. Any other write at either step returns the sequencer to read mode, and no cell changes.
- R3: After the unlock pair, the command write decodes as follows: 0xA0 selects program, 0x90 selects autoselect, 0x80 selects erase and 0x20 enters bypass. Any other value returns to read mode. Outside bypass, the command write must also address UNLOCK_ADDR0, or the sequencer returns to read mode.
- R4: A program data write stores the bitwise AND of the old word and the bus data, so bits are only cleared. The sequencer then returns to read mode, or to the command step when in bypass.
- R5: Erase needs a second unlock pair followed by a select write. 0x10 at UNLOCK_ADDR0 erases the whole array to all ones. 0x30 erases the sector that holds the written word. Any other select write returns to read mode. During an erase, `erase_busy` is 1, reads return `status_in`, and every write is ignored (0xF0 included) until `erase_done`.
- R6: Data 0x98 at word address 0x55 in read mode enters query mode. There, the word offset (byte address bits 7:0 shifted as in R1) below 0x4D selects a table byte, and any higher offset reads 0. The table holds 'Q','R','Y' at 0x10..0x12, log2 of the array byte size at 0x27, and 1 at 0x2C. Any write leaves query mode for read mode.
- R7: The same 0x98 write at 0x55 in autoselect enters a second query state. A later 0xF0 returns from that state to autoselect, not to read mode.
- R8: Data 0xF0 returns to read mode and leaves bypass from every state except three: the program data step, where 0xF0 is programmed as data; an erase; and the R7 query state.
- R9: In bypass, a program needs only 0xA0 followed by the data write, at any address. Data 0x00 written in autoselect while in bypass leaves bypass and returns to read mode.
- R10: In autoselect, word offset 0 reads ID0, offset 1 reads ID1 and offset 2 reads 0. Offsets 0x0E and 0x0F read ID2 and ID3, except that an ID word equal to 16'hFFFF gives the array word instead. All other offsets read the array.
- R11: A read returns its data on `bus_rdata` one clock after the read strobe. `bus_rdata` holds its value while no read is strobed. A read and a write in the same cycle both use the same address, and the read returns what the mode in force before that write selects.
- R12: After reset the sequencer is in read mode with bypass off, every array word is all ones, `bus_rdata` is 0 and `erase_busy` is 0.
- R13: `erase_done` during an erase returns the sequencer to read mode. If bypass was on, it returns to the command step instead, so no unlock pair is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 8*BUS_BYTES | Write data; bits 7:0 carry the command code |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8*BUS_BYTES | Registered read data |
| status_in | input | 8*BUS_BYTES | Status word from the timing block, returned during program and erase |
| erase_done | input | 1 | Pulse from the timing block ending an erase |
| erase_busy | output | 1 | High while a chip or sector erase is in progress |

## Verification
Two functions can meet in one cycle: a read strobe and a write strobe that changes the mode. The bench provokes this by strobing both together with the query-entry write. It judges the result by requiring that the registered data is the array word, and that only the following read returns a table byte. Erase completion can also coincide with a write during an erase; the write must be dropped and the state must follow `erase_done` alone. The bench exercises this next to the ignored 0xF0 inside an erase. Arithmetic sweeps over every array word and every low autoselect offset compare the design against a bench-side model of the AND-only program rule.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   typedef enum logic [3:0] {
      FS_READ,
      FS_UNLK1,
      FS_CMD,
      FS_PROG,
      FS_AUTO,
      FS_EUNLK0,
      FS_EUNLK1,
      FS_ESEL,
      FS_CHIPER,
      FS_SECER,
      FS_QRY,
      FS_AQRY
   } fcs_state_e;

   localparam logic [7:0] K_KEY_A   = 8'hAA;
   localparam logic [7:0] K_KEY_B   = 8'h55;
   localparam logic [7:0] K_ERASE   = 8'h80;
   localparam logic [7:0] K_IDENT   = 8'h90;
   localparam logic [7:0] K_PROG    = 8'hA0;
   localparam logic [7:0] K_BYPASS  = 8'h20;
   localparam logic [7:0] K_CHIP    = 8'h10;
   localparam logic [7:0] K_SECTOR  = 8'h30;
   localparam logic [7:0] K_RESET   = 8'hF0;
   localparam logic [7:0] K_QUERY   = 8'h98;
   localparam logic [7:0] K_BYP_OFF = 8'h00;
   localparam logic [10:0] QUERY_WA = 11'h055;

endpackage

// File: rtl/fcs_cmd_fsm.sv
module fcs_cmd_fsm
   import fcs_pkg::*;
#(
   parameter logic [10:0] UNLOCK_ADDR0 = 11'h555,
   parameter logic [10:0] UNLOCK_ADDR1 = 11'h2AA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [10:0] wa,
   input  logic [7:0] cmd,
   input  logic       erase_done,
   output fcs_state_e st_q,
   output logic       byp_q,
   output logic       prog_we,
   output logic       chip_er,
   output logic       sect_er
);

   fcs_state_e st_d;
   logic       byp_d;
   logic       go_read;
   logic       in_erase;
   logic       is_query;

   assign in_erase = (st_q == FS_CHIPER) || (st_q == FS_SECER);
   assign is_query = (wa == QUERY_WA) && (cmd == K_QUERY);

   always_comb begin
      st_d    = st_q;
      byp_d   = byp_q;
      prog_we = 1'b0;
      chip_er = 1'b0;
      sect_er = 1'b0;
      go_read = 1'b0;
      if (in_erase && erase_done) begin
         st_d = byp_q ? FS_CMD : FS_READ;
      end else if (we) begin
         if (cmd == K_RESET && st_q != FS_PROG && !in_erase) begin
            if (st_q == FS_AQRY) st_d = FS_AUTO;
            else                 go_read = 1'b1;
         end else begin
            case (st_q)
               FS_READ, FS_EUNLK0: begin
                  if (is_query) st_d = FS_QRY;
                  else if (wa == UNLOCK_ADDR0 && cmd == K_KEY_A)
                     st_d = (st_q == FS_READ) ? FS_UNLK1 : FS_EUNLK1;
                  else go_read = 1'b1;
               end
               FS_UNLK1, FS_EUNLK1: begin
                  if (wa == UNLOCK_ADDR1 && cmd == K_KEY_B)
                     st_d = (st_q == FS_UNLK1) ? FS_CMD : FS_ESEL;
                  else go_read = 1'b1;
               end
               FS_CMD: begin
                  if (!byp_q && wa != UNLOCK_ADDR0) go_read = 1'b1;
                  else begin
                     case (cmd)
                        K_BYPASS: byp_d = 1'b1;
                        K_ERASE:  st_d  = FS_EUNLK0;
                        K_IDENT:  st_d  = FS_AUTO;
                        K_PROG:   st_d  = FS_PROG;
                        default:  go_read = 1'b1;
                     endcase
                  end
               end
               FS_PROG: begin
                  prog_we = 1'b1;
                  st_d    = byp_q ? FS_CMD : FS_READ;
               end
               FS_AUTO: begin
                  if (byp_q && cmd == K_BYP_OFF) go_read = 1'b1;
                  else if (is_query)             st_d = FS_AQRY;
                  else                           go_read = 1'b1;
               end
               FS_ESEL: begin
                  if (cmd == K_CHIP && wa == UNLOCK_ADDR0) begin
                     chip_er = 1'b1;
                     st_d    = FS_CHIPER;
                  end else if (cmd == K_SECTOR) begin
                     sect_er = 1'b1;
                     st_d    = FS_SECER;
                  end else go_read = 1'b1;
               end
               FS_CHIPER, FS_SECER: ;
               default: go_read = 1'b1;
            endcase
         end
         if (go_read) begin
            st_d  = FS_READ;
            byp_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= FS_READ;
         byp_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         byp_q <= byp_d;
      end
   end

   // R5
   erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == FS_CHIPER || st_q == FS_SECER) && !erase_done) |=> (st_q == $past(st_q)));

   // R9
   bypass_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(byp_q) |-> $past(we && cmd == K_BYPASS && st_q == FS_CMD));

   // R7
   aqry_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FS_AQRY && we && cmd == K_RESET) |=> (st_q == FS_AUTO));

endmodule

// File: rtl/fcs_array.sv
module fcs_array #(
   parameter int DW           = 16,
   parameter int DEPTH_WORDS  = 64,
   parameter int SECTOR_WORDS = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           prog_we,
   input  logic                           chip_er,
   input  logic                           sect_er,
   input  logic [$clog2(DEPTH_WORDS)-1:0] idx,
   input  logic [DW-1:0]                  wdata,
   output logic [DW-1:0]                  rword
);

   localparam int IW = $clog2(DEPTH_WORDS);
   localparam int SW = $clog2(SECTOR_WORDS);

   logic [DW-1:0] words [DEPTH_WORDS];

   for (genvar i = 0; i < DEPTH_WORDS; i++) begin : g_word
      localparam logic [IW-1:0] MY_IDX = IW'(i);
      logic [DW-1:0] q;
      logic          sect_hit;

      assign sect_hit = (idx >> SW) == (MY_IDX >> SW);

      always_ff @(posedge clk) begin
         if (!rst_n)                         q <= '1;
         else if (chip_er || (sect_er && sect_hit)) q <= '1;
         else if (prog_we && idx == MY_IDX)  q <= q & wdata;
      end

      assign words[i] = q;

      // R4
      only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(chip_er || sect_er) |-> ((q & ~$past(q)) == '0));
   end

   assign rword = words[idx];

endmodule

// File: rtl/fcs_read_mux.sv
module fcs_read_mux
   import fcs_pkg::*;
#(
   parameter int          DW           = 16,
   parameter int          SHIFT        = 1,
   parameter int          CHIP_BYTES   = 128,
   parameter int          SECT_BYTES   = 32,
   parameter int          NUM_SECT     = 4,
   parameter logic [15:0] ID0          = 16'h0001,
   parameter logic [15:0] ID1          = 16'h227E,
   parameter logic [15:0] ID2          = 16'h2210,
   parameter logic [15:0] ID3          = 16'hFFFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          re,
   input  fcs_state_e    st,
   input  logic [7:0]    low_addr,
   input  logic [DW-1:0] arr_word,
   input  logic [DW-1:0] status_in,
   output logic [DW-1:0] rdata
);

   localparam logic [7:0]  SIZE_LOG2 = 8'($clog2(CHIP_BYTES));
   localparam logic [15:0] SECT_M1   = 16'(NUM_SECT - 1);
   localparam logic [23:0] SECT_LEN  = 24'(SECT_BYTES);

   logic [7:0]    off;
   logic [DW-1:0] id_word;
   logic [DW-1:0] sel;

   assign off = low_addr >> SHIFT;

   function automatic logic [7:0] table_byte(input logic [7:0] o);
      case (o)
         8'h10: return 8'h51;
         8'h11: return 8'h52;
         8'h12: return 8'h59;
         8'h13: return 8'h02;
         8'h15: return 8'h40;
         8'h1B: return 8'h27;
         8'h1C: return 8'h36;
         8'h1F: return 8'h07;
         8'h21: return 8'h09;
         8'h22: return 8'h0C;
         8'h23: return 8'h01;
         8'h25: return 8'h0A;
         8'h26: return 8'h0D;
         8'h27: return SIZE_LOG2;
         8'h28: return 8'h02;
         8'h2C: return 8'h01;
         8'h2D: return SECT_M1[7:0];
         8'h2E: return SECT_M1[15:8];
         8'h2F: return SECT_LEN[15:8];
         8'h30: return SECT_LEN[23:16];
         8'h40: return 8'h50;
         8'h41: return 8'h52;
         8'h42: return 8'h49;
         8'h43: return 8'h31;
         8'h44: return 8'h30;
         8'h46: return 8'h02;
         default: return 8'h00;
      endcase
   endfunction

   always_comb begin
      case (off)
         8'h00:   id_word = DW'(ID0);
         8'h01:   id_word = DW'(ID1);
         8'h02:   id_word = '0;
         8'h0E:   id_word = (ID2 == 16'hFFFF) ? arr_word : DW'(ID2);
         8'h0F:   id_word = (ID3 == 16'hFFFF) ? arr_word : DW'(ID3);
         default: id_word = arr_word;
      endcase
   end

   always_comb begin
      case (st)
         FS_AUTO:                      sel = id_word;
         FS_QRY, FS_AQRY:              sel = DW'(table_byte(off));
         FS_PROG, FS_CHIPER, FS_SECER: sel = status_in;
         default:                      sel = arr_word;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= sel;
   end

   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> $stable(rdata));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import fcs_pkg::*;
#(
   parameter int          BUS_BYTES    = 2,
   parameter int          ADDR_W       = 16,
   parameter int          DEPTH_WORDS  = 64,
   parameter int          SECTOR_WORDS = 16,
   parameter logic [10:0] UNLOCK_ADDR0 = 11'h555,
   parameter logic [10:0] UNLOCK_ADDR1 = 11'h2AA,
   parameter logic [15:0] ID0          = 16'h0001,
   parameter logic [15:0] ID1          = 16'h227E,
   parameter logic [15:0] ID2          = 16'h2210,
   parameter logic [15:0] ID3          = 16'hFFFF
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [8*BUS_BYTES-1:0] bus_wdata,
   input  logic                   bus_we,
   input  logic                   bus_re,
   output logic [8*BUS_BYTES-1:0] bus_rdata,
   input  logic [8*BUS_BYTES-1:0] status_in,
   input  logic                   erase_done,
   output logic                   erase_busy
);

   localparam int DW    = 8 * BUS_BYTES;
   localparam int SHIFT = (BUS_BYTES == 4) ? 2 : (BUS_BYTES == 2) ? 1 : 0;
   localparam int IW    = $clog2(DEPTH_WORDS);

   if (!(BUS_BYTES == 1 || BUS_BYTES == 2 || BUS_BYTES == 4)) begin : g_bad_width
      $error("BUS_BYTES must be 1, 2 or 4");
   end
   if ((DEPTH_WORDS & (DEPTH_WORDS - 1)) != 0 || DEPTH_WORDS < 2) begin : g_bad_depth
      $error("DEPTH_WORDS must be a power of two");
   end
   if ((SECTOR_WORDS & (SECTOR_WORDS - 1)) != 0 || SECTOR_WORDS > DEPTH_WORDS) begin : g_bad_sect
      $error("SECTOR_WORDS must be a power of two no larger than DEPTH_WORDS");
   end
   if (ADDR_W - SHIFT < 11 || ADDR_W - SHIFT < IW) begin : g_bad_addr
      $error("ADDR_W too small for the unlock compare or the array");
   end

   logic [ADDR_W-1:0] waddr;
   fcs_state_e        st;
   logic              byp;
   logic              prog_we, chip_er, sect_er;
   logic [DW-1:0]     arr_word;

   assign waddr = bus_addr >> SHIFT;

   fcs_cmd_fsm #(
      .UNLOCK_ADDR0(UNLOCK_ADDR0),
      .UNLOCK_ADDR1(UNLOCK_ADDR1)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (bus_we),
      .wa        (waddr[10:0]),
      .cmd       (bus_wdata[7:0]),
      .erase_done(erase_done),
      .st_q      (st),
      .byp_q     (byp),
      .prog_we   (prog_we),
      .chip_er   (chip_er),
      .sect_er   (sect_er)
   );

   fcs_array #(
      .DW          (DW),
      .DEPTH_WORDS (DEPTH_WORDS),
      .SECTOR_WORDS(SECTOR_WORDS)
   ) u_array (
      .clk    (clk),
      .rst_n  (rst_n),
      .prog_we(prog_we),
      .chip_er(chip_er),
      .sect_er(sect_er),
      .idx    (waddr[IW-1:0]),
      .wdata  (bus_wdata),
      .rword  (arr_word)
   );

   fcs_read_mux #(
      .DW        (DW),
      .SHIFT     (SHIFT),
      .CHIP_BYTES(DEPTH_WORDS * BUS_BYTES),
      .SECT_BYTES(SECTOR_WORDS * BUS_BYTES),
      .NUM_SECT  (DEPTH_WORDS / SECTOR_WORDS),
      .ID0       (ID0),
      .ID1       (ID1),
      .ID2       (ID2),
      .ID3       (ID3)
   ) u_rmux (
      .clk      (clk),
      .rst_n    (rst_n),
      .re       (bus_re),
      .st       (st),
      .low_addr (bus_addr[7:0]),
      .arr_word (arr_word),
      .status_in(status_in),
      .rdata    (bus_rdata)
   );

   assign erase_busy = (st == FS_CHIPER) || (st == FS_SECER);

endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;

   localparam logic [15:0] I0 = 16'h0001;
   localparam logic [15:0] I1 = 16'h227E;
   localparam logic [15:0] I2 = 16'h2210;
   localparam logic [15:0] I3 = 16'hFFFF;
   localparam logic [15:0] UA0B = 16'h0AAA;  // word 0x555, 16-bit bus
   localparam logic [15:0] UA1B = 16'h0554;  // word 0x2AA
   localparam logic [15:0] QRYB = 16'h00AA;  // word 0x055

   logic        clk = 0;
   logic        rst_n = 0;
   logic [15:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_we = 0;
   logic        bus_re = 0;
   logic [15:0] bus_rdata;
   logic [15:0] status_in = 16'h00A5;
   logic        erase_done = 0;
   logic        erase_busy;

   int tests = 0;
   int fails = 0;
   logic [15:0] mdl [64];

   always #10 clk = ~clk;

   flash_cmd_seq #(
      .BUS_BYTES(2), .ADDR_W(16), .DEPTH_WORDS(64), .SECTOR_WORDS(16),
      .UNLOCK_ADDR0(11'h555), .UNLOCK_ADDR1(11'h2AA),
      .ID0(I0), .ID1(I1), .ID2(I2), .ID3(I3)
   ) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .status_in(status_in), .erase_done(erase_done), .erase_busy(erase_busy)
   );

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [15:0] v);
      bus_re = 1; bus_addr = a;
      @(negedge clk);
      bus_re = 0;
      v = bus_rdata;
   endtask

   task automatic unlock();
      wr(UA0B, 16'h00AA);
      wr(UA1B, 16'h0055);
   endtask

   task automatic program_word(input int w, input logic [15:0] d);
      unlock();
      wr(UA0B, 16'h00A0);
      wr(16'(w << 1), d);
      mdl[w] = mdl[w] & d;
   endtask

   task automatic sweep(input string req);
      logic [15:0] v;
      for (int w = 0; w < 64; w++) begin
         rd(16'(w << 1), v);
         chk(req, v, mdl[w]);
      end
   endtask

   initial begin
      #4_000_000;
      fails++;
      $display("FAIL watchdog got hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [15:0] v;
      for (int w = 0; w < 64; w++) mdl[w] = 16'hFFFF;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R12 reset state
      chk("R12 rdata", bus_rdata, 16'h0000);
      chk("R12 busy", {15'b0, erase_busy}, 16'h0000);
      sweep("R12 erased");

      // R4 program sweep, then AND over existing data
      for (int w = 0; w < 64; w++) program_word(w, 16'hFFFF ^ (16'(w) * 16'h0411));
      program_word(5, 16'hF0F0);
      program_word(33, 16'h0FFF);
      sweep("R4");

      // R2 wrong second unlock address then stray writes
      wr(UA0B, 16'h00AA);
      wr(16'h0556, 16'h0055);
      wr(UA0B, 16'h00A0);
      wr(16'h0006, 16'h0000);
      rd(16'h0006, v); chk("R2", v, mdl[3]);

      // R3 command not at unlock address outside bypass
      unlock();
      wr(16'h000E, 16'h00A0);
      wr(16'h000E, 16'h0000);
      rd(16'h000E, v); chk("R3 addr", v, mdl[7]);
      // R3 unknown command code
      unlock();
      wr(UA0B, 16'h0077);
      wr(16'h0010, 16'h0000);
      rd(16'h0010, v); chk("R3 code", v, mdl[8]);

      // R1 aliasing on high word-address bits
      wr(16'h1AAA, 16'h00AA);
      wr(16'h1554, 16'h0055);
      wr(16'h1AAA, 16'h00A0);
      wr(16'h0012, 16'h00FF);
      mdl[9] = mdl[9] & 16'h00FF;
      rd(16'h0012, v); chk("R1", v, mdl[9]);

      // R10 autoselect offsets
      unlock();
      wr(UA0B, 16'h0090);
      for (int o = 0; o < 16; o++) begin
         logic [15:0] e;
         case (o)
            0: e = I0;
            1: e = I1;
            2: e = 16'h0000;
            14: e = I2;
            default: e = mdl[o];
         endcase
         rd(16'(o << 1), v);
         chk("R10", v, e);
      end
      rd(16'h0100, v); chk("R10 low byte", v, I0);

      // R7 query from autoselect, 0xF0 back to autoselect
      wr(QRYB, 16'h0098);
      rd(16'h0020, v); chk("R7 table", v, 16'h0051);
      wr(16'h0000, 16'h00F0);
      rd(16'h0000, v); chk("R7 back", v, I0);
      wr(16'h0000, 16'h00F0);
      rd(16'h0000, v); chk("R8 from auto", v, mdl[0]);

      // R6 query from read mode
      wr(QRYB, 16'h0098);
      rd(16'h0020, v); chk("R6 Q", v, 16'h0051);
      rd(16'h0022, v); chk("R6 R", v, 16'h0052);
      rd(16'h0024, v); chk("R6 Y", v, 16'h0059);
      rd(16'h004E, v); chk("R6 size", v, 16'h0007);
      rd(16'h0058, v); chk("R6 regions", v, 16'h0001);
      rd(16'h009A, v); chk("R6 beyond", v, 16'h0000);
      rd(16'h00FE, v); chk("R6 top", v, 16'h0000);
      wr(16'h0000, 16'h0000);
      rd(16'h0000, v); chk("R6 exit", v, mdl[0]);

      // R8 0xF0 as program data, 0xF0 during command step
      program_word(11, 16'h00F0);
      rd(16'h0016, v); chk("R8 data", v, mdl[11]);
      unlock();
      wr(UA0B, 16'h00F0);
      wr(16'h0018, 16'h0000);
      rd(16'h0018, v); chk("R8 reset", v, mdl[12]);

      // R9 bypass programs
      unlock();
      wr(UA0B, 16'h0020);
      wr(16'h001A, 16'h00A0); wr(16'h001A, 16'h0F0F);
      mdl[13] = mdl[13] & 16'h0F0F;
      wr(16'h0300, 16'h00A0); wr(16'h001C, 16'h3333);
      mdl[14] = mdl[14] & 16'h3333;
      rd(16'h001A, v); chk("R9 a", v, mdl[13]);
      rd(16'h001C, v); chk("R9 b", v, mdl[14]);
      wr(16'h0000, 16'h0090);
      wr(16'h0000, 16'h0000);
      rd(16'h0000, v); chk("R9 exit", v, mdl[0]);
      wr(16'h001E, 16'h00A0); wr(16'h001E, 16'h0000);
      rd(16'h001E, v); chk("R9 off", v, mdl[15]);

      // R5 sector erase of words 16..31
      unlock(); wr(UA0B, 16'h0080); unlock();
      wr(16'h0028, 16'h0030);
      chk("R5 busy", {15'b0, erase_busy}, 16'h0001);
      rd(16'h0028, v); chk("R5 status", v, 16'h00A5);
      wr(UA0B, 16'h00F0);
      chk("R5 f0 ignored", {15'b0, erase_busy}, 16'h0001);
      // erase_done together with a write: write dropped
      erase_done = 1; bus_we = 1; bus_addr = 16'h0000; bus_wdata = 16'h0098;
      @(negedge clk);
      erase_done = 0; bus_we = 0;
      chk("R13 idle", {15'b0, erase_busy}, 16'h0000);
      for (int w = 16; w < 32; w++) mdl[w] = 16'hFFFF;
      sweep("R5 sector");

      // R5 chip erase at wrong address is refused
      unlock(); wr(UA0B, 16'h0080); unlock();
      wr(16'h0006, 16'h0010);
      chk("R5 refused", {15'b0, erase_busy}, 16'h0000);
      rd(16'h0006, v); chk("R5 kept", v, mdl[3]);

      // R13 chip erase in bypass returns to command step
      unlock(); wr(UA0B, 16'h0020);
      wr(16'h0000, 16'h0080); unlock();
      wr(UA0B, 16'h0010);
      chk("R5 chip busy", {15'b0, erase_busy}, 16'h0001);
      erase_done = 1; @(negedge clk); erase_done = 0;
      for (int w = 0; w < 64; w++) mdl[w] = 16'hFFFF;
      wr(16'h0004, 16'h00A0); wr(16'h0004, 16'h1234);
      mdl[2] = 16'h1234;
      rd(16'h0004, v); chk("R13 bypass", v, 16'h1234);
      wr(16'h0000, 16'h00F0);
      sweep("R5 chip");

      // R11 read and write in the same cycle
      bus_we = 1; bus_re = 1; bus_addr = QRYB; bus_wdata = 16'h0098;
      @(negedge clk);
      bus_we = 0; bus_re = 0;
      chk("R11 same cycle", bus_rdata, mdl[21]);
      @(negedge clk);
      chk("R11 hold", bus_rdata, mdl[21]);
      rd(16'h0020, v); chk("R11 after", v, 16'h0051);
      wr(16'h0000, 16'h00F0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule